// File: doc/BRIEF.md
# Masked-Command GPIO Port with Level Alarms

A general-purpose I/O port of parameterised width. Each bit has a direction register and an output shadow register that drives the pin. Software never writes these registers as a whole word. It issues commands that carry a mask. Each command sets or clears the masked shadow bits, turns the masked bits into inputs or outputs, or arms or disarms a level alarm on them. The input pins pass through a two-stage synchroniser. Reads and alarm comparisons see only the synchronised values.

Each bit can be armed to alarm while its input is high or while it is low. The per-bit alarm status and an OR of all bits come out as level signals. A bit's alarm stays active until its input level changes or the bit is disarmed. The read commands, and the two direction commands that also return data, place their result on a registered data output one cycle after the command. A valid pulse marks that result.

Top module: `gpio_alarm_port`

## Requirements
- R1: While and after reset, all bits are inputs (`pin_oe_o` = 0), the shadow is 0 (`pin_o` = 0), no bit is armed (`alarm_bits_o` = 0, `alarm_o` = 0), `rd_valid_o` = 0 and `rd_data_o` = 0.
- R2: Opcode 4'h1 (set) forces to 1 every shadow bit whose mask bit is 1. It leaves the other shadow bits unchanged. The change shows on `pin_o` after the clock edge that accepts the command.
- R3: Opcode 4'h2 (clear) forces to 0 every shadow bit whose mask bit is 1. It leaves the other shadow bits unchanged. The change shows on `pin_o` after the accepting edge.
- R4: `pin_oe_o` bit 1 means output and bit 0 means input. Opcode 4'h7 makes the masked bits outputs. Opcode 4'h6 makes the masked bits inputs. Unmasked bits keep their direction.
- R5: Opcode 4'h6 returns the synchronised input pins on `rd_data_o`. Opcode 4'h7 returns the output shadow. Each value is the one held on the edge that accepts the command.
- R6: Opcode 4'h8 returns the synchronised input pins and opcode 4'h9 returns the output shadow. For opcodes 4'h6 to 4'h9, `rd_valid_o` is high for exactly the one cycle after the accepting edge, with the result on `rd_data_o`. At all other times `rd_valid_o` is low and `rd_data_o` holds its last result.
- R7: A change on `pin_i` reaches reads and alarms after exactly two rising clock edges.
- R8: Opcode 4'h3 arms the masked bits to alarm while their input is 1. Opcode 4'h4 arms them to alarm while their input is 0. Arming one polarity removes the other polarity from those bits.
- R9: Opcode 4'h5 disarms both polarities on the masked bits and leaves the other bits armed as before.
- R10: `alarm_bits_o[i]` is 1 exactly when bit i is armed high and its synchronised input is 1, or armed low and its synchronised input is 0. `alarm_o` is the OR of all bits. Both are levels with no latching.
- R11: Opcodes 4'h0 and 4'hA to 4'hF have no effect on the shadow, the direction or the arming, and give no `rd_valid_o` pulse. Any opcode presented with `cmd_valid_i` low has the same lack of effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Command opcode |
| cmd_data_i | input | WIDTH | Bit mask for the command |
| pin_i | input | WIDTH | Asynchronous input pins |
| pin_o | output | WIDTH | Output shadow driving the pins |
| pin_oe_o | output | WIDTH | Per-bit direction, 1 = output |
| rd_data_o | output | WIDTH | Registered read result |
| rd_valid_o | output | 1 | Read result valid, one cycle |
| alarm_bits_o | output | WIDTH | Per-bit alarm status |
| alarm_o | output | 1 | OR of all alarm bits |

## Verification
An arming or disarming command can be accepted on the same edge as an input transition that leaves the synchroniser. The alarm output then depends on the new arming and the new level together. The bench provokes this by changing the pins at random on every cycle while random commands, including invalid opcodes and strobe-less opcodes, are issued. A make-input command that meets a pin transition is a second case: it must return the value held before the edge. A behavioural model with its own two-entry pin history predicts the alarm bits, the read data and the port state, and the bench compares them every cycle.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'h0,
    OP_SET     = 4'h1,
    OP_CLR     = 4'h2,
    OP_ARM_HI  = 4'h3,
    OP_ARM_LO  = 4'h4,
    OP_DISARM  = 4'h5,
    OP_MK_IN   = 4'h6,
    OP_MK_OUT  = 4'h7,
    OP_RD_IN   = 4'h8,
    OP_RD_OUT  = 4'h9
  } gpio_op_e;

  typedef struct packed {
    logic set;
    logic clr;
    logic arm_hi;
    logic arm_lo;
    logic disarm;
    logic mk_in;
    logic mk_out;
    logic rd_in;
    logic rd_out;
  } gpio_cmd_t;

endpackage

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
  import gpio_alarm_pkg::*;
(
  input  logic       valid_i,
  input  logic [3:0] op_i,
  output gpio_cmd_t  cmd_o
);

  always_comb begin
    cmd_o = '0;
    if (valid_i) begin
      case (op_i)
        OP_SET:    cmd_o.set    = 1'b1;
        OP_CLR:    cmd_o.clr    = 1'b1;
        OP_ARM_HI: cmd_o.arm_hi = 1'b1;
        OP_ARM_LO: cmd_o.arm_lo = 1'b1;
        OP_DISARM: cmd_o.disarm = 1'b1;
        OP_MK_IN:  cmd_o.mk_in  = 1'b1;
        OP_MK_OUT: cmd_o.mk_out = 1'b1;
        OP_RD_IN:  cmd_o.rd_in  = 1'b1;
        OP_RD_OUT: cmd_o.rd_out = 1'b1;
        default:   cmd_o = '0;
      endcase
    end
  end

  // at most one strobe per cycle
  always_comb a_r11_onehot: assert ($onehot0(cmd_o));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             mk_in_i,
  input  logic             mk_out_i,
  input  logic             rd_in_i,
  input  logic             rd_out_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] shadow_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_valid_o
);

  logic [WIDTH-1:0] shadow_q, dir_q, rd_data_q;
  logic             rd_valid_q;
  logic             ret_in, ret_out;

  assign ret_in  = rd_in_i | mk_in_i;
  assign ret_out = rd_out_i | mk_out_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (set_i) begin
      shadow_q <= shadow_q | mask_i;
    end else if (clr_i) begin
      shadow_q <= shadow_q & ~mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (mk_out_i) begin
      dir_q <= dir_q | mask_i;
    end else if (mk_in_i) begin
      dir_q <= dir_q & ~mask_i;
    end
  end

  // result reflects state held at the accepting edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= ret_in | ret_out;
      if (ret_in)       rd_data_q <= sync_i;
      else if (ret_out) rd_data_q <= shadow_q;
    end
  end

  assign shadow_o   = shadow_q;
  assign dir_o      = dir_q;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  a_r2_set_forces_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((shadow_q & $past(mask_i)) == $past(mask_i)));
  a_r3_clr_forces_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((shadow_q & $past(mask_i)) == '0));
  a_r4_mk_out_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_out_i |=> ((dir_q & $past(mask_i)) == $past(mask_i)));
  a_r4_mk_in_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_in_i |=> ((dir_q & $past(mask_i)) == '0));
  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_in_i | rd_out_i | mk_in_i | mk_out_i) |=> rd_valid_q);
  a_r6_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_in_i | rd_out_i | mk_in_i | mk_out_i) |=> !rd_valid_q);
  a_r6_rd_out_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_out_i |=> (rd_data_q == $past(shadow_q)));
  a_r6_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_in_i | rd_out_i | mk_in_i | mk_out_i) |=> $stable(rd_data_q));

endmodule

// File: rtl/gpio_alarm_unit.sv
module gpio_alarm_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_hi_i,
  input  logic             arm_lo_i,
  input  logic             disarm_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] alarm_bits_o,
  output logic             alarm_o
);

  logic [WIDTH-1:0] arm_hi_q, arm_lo_q;

  // one polarity per bit: arming one side drops the other
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_hi_q <= '0;
      arm_lo_q <= '0;
    end else if (arm_hi_i) begin
      arm_hi_q <= arm_hi_q | mask_i;
      arm_lo_q <= arm_lo_q & ~mask_i;
    end else if (arm_lo_i) begin
      arm_lo_q <= arm_lo_q | mask_i;
      arm_hi_q <= arm_hi_q & ~mask_i;
    end else if (disarm_i) begin
      arm_hi_q <= arm_hi_q & ~mask_i;
      arm_lo_q <= arm_lo_q & ~mask_i;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign alarm_bits_o[b] = (arm_hi_q[b] & sync_i[b]) | (arm_lo_q[b] & ~sync_i[b]);
  end

  assign alarm_o = |alarm_bits_o;

  a_r8_one_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_hi_q & arm_lo_q) == '0);
  a_r8_arm_hi_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_hi_i |=> ((arm_hi_q & $past(mask_i)) == $past(mask_i)));
  a_r9_disarm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> (((arm_hi_q | arm_lo_q) & $past(mask_i)) == '0));
  a_r10_alarm_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> ((arm_hi_q | arm_lo_q) != '0));

endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
  import gpio_alarm_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_op_i,
  input  logic [WIDTH-1:0] cmd_data_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] alarm_bits_o,
  output logic             alarm_o
);

  gpio_cmd_t        cmd;
  logic [WIDTH-1:0] pin_sync;

  gpio_cmd_decode u_decode (
    .valid_i (cmd_valid_i),
    .op_i    (cmd_op_i),
    .cmd_o   (cmd)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (cmd.set),
    .clr_i      (cmd.clr),
    .mk_in_i    (cmd.mk_in),
    .mk_out_i   (cmd.mk_out),
    .rd_in_i    (cmd.rd_in),
    .rd_out_i   (cmd.rd_out),
    .mask_i     (cmd_data_i),
    .sync_i     (pin_sync),
    .shadow_o   (pin_o),
    .dir_o      (pin_oe_o),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  gpio_alarm_unit #(.WIDTH(WIDTH)) u_alarm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_hi_i     (cmd.arm_hi),
    .arm_lo_i     (cmd.arm_lo),
    .disarm_i     (cmd.disarm),
    .mask_i       (cmd_data_i),
    .sync_i       (pin_sync),
    .alarm_bits_o (alarm_bits_o),
    .alarm_o      (alarm_o)
  );

  a_r11_invalid_keeps_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_op_i == 4'h0 || cmd_op_i >= 4'hA)
      |=> ($stable(pin_o) && $stable(pin_oe_o) && !rd_valid_o));

endmodule

// File: tb/gpio_alarm_port_bench.sv
module gpio_alarm_port_bench;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [3:0]   cmd_op = '0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe, rd_data, alarm_bits;
  logic         rd_valid, alarm;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmp_en = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  gpio_alarm_port #(.WIDTH(W)) u_gpio_alarm_port (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_data_i   (cmd_data),
    .pin_i        (pin_in),
    .pin_o        (pin_out),
    .pin_oe_o     (pin_oe),
    .rd_data_o    (rd_data),
    .rd_valid_o   (rd_valid),
    .alarm_bits_o (alarm_bits),
    .alarm_o      (alarm)
  );

  // behavioural reference: pin history of two samples, plain state words
  logic [W-1:0] m_hist[2];
  logic [W-1:0] m_sh, m_dir, m_hi, m_lo, m_rd;
  logic         m_rv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist[0] = '0; m_hist[1] = '0;
      m_sh = '0; m_dir = '0; m_hi = '0; m_lo = '0; m_rd = '0; m_rv = 0;
    end else begin
      m_rv = 0;
      if (cmd_valid) begin
        case (cmd_op)
          4'h1: m_sh = m_sh | cmd_data;
          4'h2: m_sh = m_sh & ~cmd_data;
          4'h3: begin m_hi = m_hi | cmd_data; m_lo = m_lo & ~cmd_data; end
          4'h4: begin m_lo = m_lo | cmd_data; m_hi = m_hi & ~cmd_data; end
          4'h5: begin m_hi = m_hi & ~cmd_data; m_lo = m_lo & ~cmd_data; end
          4'h6: begin m_rd = m_hist[1]; m_rv = 1; m_dir = m_dir & ~cmd_data; end
          4'h7: begin m_rd = m_sh; m_rv = 1; m_dir = m_dir | cmd_data; end
          4'h8: begin m_rd = m_hist[1]; m_rv = 1; end
          4'h9: begin m_rd = m_sh; m_rv = 1; end
          default: ;
        endcase
      end
      m_hist[1] = m_hist[0];
      m_hist[0] = pin_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_alarm();
    return (m_hi & m_hist[1]) | (m_lo & ~m_hist[1]);
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(pin_out == m_sh, phase, "pin_o R2 R3", 32'(pin_out), 32'(m_sh));
      chk(pin_oe == m_dir, phase, "pin_oe_o R4", 32'(pin_oe), 32'(m_dir));
      chk(rd_valid == m_rv, phase, "rd_valid_o R6", 32'(rd_valid), 32'(m_rv));
      chk(rd_data == m_rd, phase, "rd_data_o R5 R6", 32'(rd_data), 32'(m_rd));
      chk(alarm_bits == exp_alarm(), phase, "alarm_bits_o R8 R9 R10",
          32'(alarm_bits), 32'(exp_alarm()));
      chk(alarm == (exp_alarm() != '0), phase, "alarm_o R10",
          32'(alarm), 32'(exp_alarm() != '0));
    end
  end

  task automatic issue(input logic [3:0] op, input logic [W-1:0] d);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0; cmd_op = '0; cmd_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(pin_out == '0 && pin_oe == '0 && alarm_bits == '0 && !alarm && !rd_valid && rd_data == '0,
        "R1", "reset outputs", 32'({pin_out, pin_oe} != '0), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(pin_out == '0 && pin_oe == '0 && !alarm, "R1", "after release",
        32'(pin_out | pin_oe), 32'd0);
    cmp_en = 1;

    phase = "R2";
    issue(4'h1, 18'h0F0F0);
    issue(4'h1, 18'h30001);
    phase = "R3";
    issue(4'h2, 18'h000F1);
    phase = "R4";
    issue(4'h7, 18'h3C00F);
    issue(4'h6, 18'h0000C);
    phase = "R6";
    pin_in = 18'h2A5A5;
    repeat (3) @(negedge clk);
    issue(4'h8, '0);
    issue(4'h9, '0);
    @(negedge clk);
    chk(rd_data == m_rd && !rd_valid, "R6", "data held", 32'(rd_data), 32'(m_rd));

    // R7: arm bit 0 high, raise pin 0; alarm appears after two edges
    phase = "R7";
    pin_in = '0;
    repeat (3) @(negedge clk);
    issue(4'h3, 18'h00001);
    pin_in = 18'h00001;
    @(negedge clk);
    chk(alarm == 1'b0, "R7", "alarm after one edge", 32'(alarm), 32'd0);
    @(negedge clk);
    chk(alarm == 1'b1, "R7", "alarm after two edges", 32'(alarm), 32'd1);

    // R8 polarity swap: arm bit 0 low while pin high clears alarm
    phase = "R8";
    issue(4'h4, 18'h00001);
    chk(alarm_bits[0] == 1'b0, "R8", "low-armed bit with high pin", 32'(alarm_bits[0]), 32'd0);
    pin_in = '0;
    repeat (2) @(negedge clk);
    chk(alarm_bits[0] == 1'b1, "R8", "low-armed bit with low pin", 32'(alarm_bits[0]), 32'd1);

    phase = "R9";
    issue(4'h4, 18'h3FFFF);
    issue(4'h5, 18'h0FFFF);
    chk(alarm_bits == 18'h30000, "R9", "partial disarm", 32'(alarm_bits), 32'h30000);
    issue(4'h5, 18'h3FFFF);
    chk(!alarm, "R9", "full disarm", 32'(alarm), 32'd0);

    phase = "R10";
    issue(4'h3, 18'h00F00);
    pin_in = 18'h00300;
    repeat (2) @(negedge clk);
    chk(alarm_bits == 18'h00300, "R10", "per-bit level", 32'(alarm_bits), 32'h00300);
    pin_in = '0;
    repeat (2) @(negedge clk);
    chk(!alarm, "R10", "alarm drops with level", 32'(alarm), 32'd0);

    phase = "R11";
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op >= 10) issue(4'(op), 18'h3FFFF);
    end
    cmd_op = 4'h1; cmd_data = 18'h3FFFF; // no strobe
    @(negedge clk);
    cmd_op = '0; cmd_data = '0;
    chk(pin_out == m_sh && !rd_valid, "R11", "ignored commands", 32'(pin_out), 32'(m_sh));

    // R5 with pin transitions meeting make-input and arming in one cycle
    phase = "R5";
    for (int i = 0; i < 3000; i++) begin
      pin_in = ($urandom % 3 == 0) ? W'($urandom) : pin_in;
      cmd_valid = ($urandom % 3 != 0);
      cmd_op = 4'($urandom_range(0, 15));
      cmd_data = W'($urandom);
      @(negedge clk);
    end
    cmd_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule